// File: doc/BRIEF.md
# Interrupt Router Configuration Register Window

This block is the configuration register file of a small I/O interrupt router. Software reaches it through an index/data pair. It first writes an 8-bit index, then reads or writes a 32-bit data word at that index. Behind the window are four kinds of register:

- an identification register, which holds a 4-bit router ID;
- a fixed version register;
- an arbitration register, which mirrors the ID;
- a redirection table with two 32-bit words per input pin.

The block decodes each access by index and applies a write mask for each register, so read-only fields stay intact. It drives every pin's redirection fields straight out to the delivery logic as parallel vectors. These fields are the vector, delivery mode, destination mode, trigger mode, mask and destination.

The delivery logic returns two live status bits per pin: a busy flag and a remote-acknowledge-pending flag. The block shows these inside each entry's low word. Software cannot write them.

Top module: `irqr_regs`

## Requirements
- R1: After reset the index reads 0, the identification register reads 0, and every entry's low word reads 0x00010000 (mask bit 16 set, all else clear). All exported mask bits are 1 and all exported vectors are 0.
- R2: Index 0x00 is the identification register. A write changes only bits 27:24, and all other bits read 0.
- R3: Index 0x01 is the version register. It reads {8'h00, NPIN-1, 8'h00, VERSION}, which is 0x00170011 by default, and writes do not change it.
- R4: Index 0x02 is the arbitration register. It reads the ID field in bits 27:24, with every other bit 0. Writes to index 0x02 have no effect.
- R5: Pin n's low word is at index 0x10+2n, laid out as: vector 7:0, delivery mode 10:8, destination mode 11, trigger mode 15 (1 = level) and mask 16. Written values read back and appear on the pin's exported fields.
- R6: Pin n's high word is at index 0x10+2n+1, with the destination in bits 31:24 and every other bit reading 0. A high-word write changes only the destination, and a low-word write leaves the destination unchanged.
- R7: Low-word bits 12 (busy) and 14 (remote pending) read the live status inputs of that pin. Software writes to them are ignored.
- R8: The index register reads back as written. Reads of any index that is not implemented return 0.
- R9: Read data is registered. It reflects the index that was held during the previous cycle.
- R10: A data write updates the exported fields at the same clock edge that stores it. Without a write, the exported fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Load the index register |
| idx_wdata | input | IDX_W | New index value |
| data_wr | input | 1 | Write data_wdata to the register selected by the index |
| data_wdata | input | 32 | Write data |
| st_remote_irr | input | NPIN | Per-pin remote-acknowledge-pending status from the delivery logic |
| st_busy | input | NPIN | Per-pin delivery-busy status from the delivery logic |
| idx_rdata | output | IDX_W | Current index |
| data_rdata | output | 32 | Registered read data |
| pin_vector | output | NPIN*8 | Vector per pin |
| pin_dlv_mode | output | NPIN*3 | Delivery mode per pin |
| pin_dest_mode | output | NPIN | Destination mode per pin |
| pin_trig_level | output | NPIN | Trigger mode per pin, 1 for level |
| pin_mask | output | NPIN | Mask per pin |
| pin_dest | output | NPIN*8 | Destination per pin |

## Verification
An index load takes effect at the next edge, and the matching read word is registered at the edge after that. Each read therefore expects its result two edges after the index is driven. The driver puts an expected item with that due cycle into a queue, and the monitor compares it on the falling edge of the cycle it names. Exported fields are checked on the falling edge right after the write edge. One check holds a new index for just one edge and confirms that the read word still shows the previous register.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

   localparam int DATA_W    = 32;
   localparam int VEC_W     = 8;
   localparam int DMODE_W   = 3;
   localparam int DEST_W    = 8;
   localparam int ID_W      = 4;

   localparam int IDX_ID       = 8'h00;
   localparam int IDX_VER      = 8'h01;
   localparam int IDX_ARB      = 8'h02;
   localparam int IDX_TBL_BASE = 8'h10;

   localparam int LO_VEC_LSB   = 0;
   localparam int LO_DMODE_LSB = 8;
   localparam int LO_DSTM_BIT  = 11;
   localparam int LO_BUSY_BIT  = 12;
   localparam int LO_RIRR_BIT  = 14;
   localparam int LO_TRIG_BIT  = 15;
   localparam int LO_MASK_BIT  = 16;
   localparam int HI_DEST_LSB  = 24;
   localparam int ID_LSB       = 24;

   typedef struct packed {
      logic                mask;
      logic                trig;
      logic                dstm;
      logic [DMODE_W-1:0]  dmode;
      logic [VEC_W-1:0]    vec;
      logic [DEST_W-1:0]   dest;
   } redir_t;

endpackage

// File: rtl/irqr_decode.sv
module irqr_decode
   import irqr_pkg::*;
#(
   parameter int NPIN  = 24,
   parameter int IDX_W = 8,
   localparam int PIN_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             data_wr,
   output logic             wr_id,
   output logic [NPIN-1:0]  wr_lo,
   output logic [NPIN-1:0]  wr_hi,
   output logic             tbl_hit,
   output logic             tbl_hi,
   output logic [PIN_W-1:0] tbl_pin
);

   logic [IDX_W-1:0] off;

   always_comb begin
      off     = idx - IDX_W'(IDX_TBL_BASE);
      tbl_hit = (idx >= IDX_W'(IDX_TBL_BASE)) && (int'(off) < 2 * NPIN);
      tbl_hi  = off[0];
      tbl_pin = off[PIN_W:1];
      wr_id   = data_wr && (idx == IDX_W'(IDX_ID));
   end

   for (genvar n = 0; n < NPIN; n++) begin : g_sel
      assign wr_lo[n] = data_wr && tbl_hit && !tbl_hi && (tbl_pin == PIN_W'(n));
      assign wr_hi[n] = data_wr && tbl_hit &&  tbl_hi && (tbl_pin == PIN_W'(n));
   end

endmodule

// File: rtl/irqr_id_block.sv
module irqr_id_block
   import irqr_pkg::*;
#(
   parameter int         NPIN       = 24,
   parameter logic [7:0] VERSION    = 8'h11,
   parameter bit         ARB_AS_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_id,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] id_word,
   output logic [DATA_W-1:0] ver_word,
   output logic [DATA_W-1:0] arb_word
);

   localparam logic [7:0] MAX_ENTRY = 8'(NPIN - 1);

   logic [ID_W-1:0] id_q;
   logic [ID_W-1:0] arb_id;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     id_q <= '0;
      else if (wr_id) id_q <= wdata[ID_LSB +: ID_W];
   end

   if (ARB_AS_REG) begin : g_arb_reg
      logic [ID_W-1:0] arb_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     arb_q <= '0;
         else if (wr_id) arb_q <= wdata[ID_LSB +: ID_W];
      end
      assign arb_id = arb_q;
   end else begin : g_arb_wire
      assign arb_id = id_q;
   end

   always_comb begin
      id_word  = '0;
      arb_word = '0;
      id_word[ID_LSB +: ID_W]  = id_q;
      arb_word[ID_LSB +: ID_W] = arb_id;
      ver_word = {8'h00, MAX_ENTRY, 8'h00, VERSION};
   end

endmodule

// File: rtl/irqr_redir_entry.sv
module irqr_redir_entry
   import irqr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic              st_irr,
   input  logic              st_busy,
   output redir_t            cfg,
   output logic [DATA_W-1:0] lo_word,
   output logic [DATA_W-1:0] hi_word
);

   redir_t q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= '0;
         q.mask <= 1'b1;
      end else begin
         if (wr_lo) begin
            q.vec   <= wdata[LO_VEC_LSB +: VEC_W];
            q.dmode <= wdata[LO_DMODE_LSB +: DMODE_W];
            q.dstm  <= wdata[LO_DSTM_BIT];
            q.trig  <= wdata[LO_TRIG_BIT];
            q.mask  <= wdata[LO_MASK_BIT];
         end
         if (wr_hi) begin
            q.dest  <= wdata[HI_DEST_LSB +: DEST_W];
         end
      end
   end

   always_comb begin
      lo_word = '0;
      lo_word[LO_VEC_LSB +: VEC_W]     = q.vec;
      lo_word[LO_DMODE_LSB +: DMODE_W] = q.dmode;
      lo_word[LO_DSTM_BIT]             = q.dstm;
      lo_word[LO_BUSY_BIT]             = st_busy;
      lo_word[LO_RIRR_BIT]             = st_irr;
      lo_word[LO_TRIG_BIT]             = q.trig;
      lo_word[LO_MASK_BIT]             = q.mask;
      hi_word = '0;
      hi_word[HI_DEST_LSB +: DEST_W]   = q.dest;
   end

   assign cfg = q;

endmodule

// File: rtl/irqr_rd_mux.sv
module irqr_rd_mux
   import irqr_pkg::*;
#(
   parameter int NPIN  = 24,
   parameter int IDX_W = 8,
   localparam int PIN_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
   input  logic [IDX_W-1:0]             idx,
   input  logic                         tbl_hit,
   input  logic                         tbl_hi,
   input  logic [PIN_W-1:0]             tbl_pin,
   input  logic [DATA_W-1:0]            id_word,
   input  logic [DATA_W-1:0]            ver_word,
   input  logic [DATA_W-1:0]            arb_word,
   input  logic [NPIN-1:0][DATA_W-1:0]  lo_words,
   input  logic [NPIN-1:0][DATA_W-1:0]  hi_words,
   output logic [DATA_W-1:0]            rdata
);

   always_comb begin
      rdata = '0;
      if (idx == IDX_W'(IDX_ID))       rdata = id_word;
      else if (idx == IDX_W'(IDX_VER)) rdata = ver_word;
      else if (idx == IDX_W'(IDX_ARB)) rdata = arb_word;
      else if (tbl_hit)                rdata = tbl_hi ? hi_words[tbl_pin] : lo_words[tbl_pin];
   end

endmodule

// File: rtl/irqr_regs.sv
module irqr_regs
   import irqr_pkg::*;
#(
   parameter int         NPIN       = 24,
   parameter int         IDX_W      = 8,
   parameter logic [7:0] VERSION    = 8'h11,
   parameter bit         ARB_AS_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 idx_wr,
   input  logic [IDX_W-1:0]     idx_wdata,
   input  logic                 data_wr,
   input  logic [31:0]          data_wdata,
   input  logic [NPIN-1:0]      st_remote_irr,
   input  logic [NPIN-1:0]      st_busy,
   output logic [IDX_W-1:0]     idx_rdata,
   output logic [31:0]          data_rdata,
   output logic [NPIN*8-1:0]    pin_vector,
   output logic [NPIN*3-1:0]    pin_dlv_mode,
   output logic [NPIN-1:0]      pin_dest_mode,
   output logic [NPIN-1:0]      pin_trig_level,
   output logic [NPIN-1:0]      pin_mask,
   output logic [NPIN*8-1:0]    pin_dest
);

   localparam int PIN_W   = (NPIN > 1) ? $clog2(NPIN) : 1;
   localparam int TBL_END = IDX_TBL_BASE + 2 * NPIN;

   if (NPIN < 1 || NPIN > 256)     begin : g_bad_npin  $error("NPIN out of range"); end
   if (IDX_W < 8 || IDX_W > 16)    begin : g_bad_idxw  $error("IDX_W out of range"); end
   if (TBL_END > (1 << IDX_W))     begin : g_bad_table $error("table exceeds index space"); end

   logic [IDX_W-1:0]            idx_q;
   logic [DATA_W-1:0]           rdata_q;
   logic [DATA_W-1:0]           rd_next;
   logic                        wr_id;
   logic [NPIN-1:0]             wr_lo;
   logic [NPIN-1:0]             wr_hi;
   logic                        tbl_hit;
   logic                        tbl_hi;
   logic [PIN_W-1:0]            tbl_pin;
   logic [DATA_W-1:0]           id_word;
   logic [DATA_W-1:0]           ver_word;
   logic [DATA_W-1:0]           arb_word;
   logic [NPIN-1:0][DATA_W-1:0] lo_words;
   logic [NPIN-1:0][DATA_W-1:0] hi_words;
   redir_t                      cfg [NPIN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx_q <= '0;
      else if (idx_wr) idx_q <= idx_wdata;
   end

   irqr_decode #(.NPIN(NPIN), .IDX_W(IDX_W)) u_dec (
      .idx     (idx_q),
      .data_wr (data_wr),
      .wr_id   (wr_id),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .tbl_hit (tbl_hit),
      .tbl_hi  (tbl_hi),
      .tbl_pin (tbl_pin)
   );

   irqr_id_block #(.NPIN(NPIN), .VERSION(VERSION), .ARB_AS_REG(ARB_AS_REG)) u_id (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_id    (wr_id),
      .wdata    (data_wdata),
      .id_word  (id_word),
      .ver_word (ver_word),
      .arb_word (arb_word)
   );

   for (genvar n = 0; n < NPIN; n++) begin : g_pin
      irqr_redir_entry u_ent (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_lo   (wr_lo[n]),
         .wr_hi   (wr_hi[n]),
         .wdata   (data_wdata),
         .st_irr  (st_remote_irr[n]),
         .st_busy (st_busy[n]),
         .cfg     (cfg[n]),
         .lo_word (lo_words[n]),
         .hi_word (hi_words[n])
      );
      assign pin_vector[n*8 +: 8]   = cfg[n].vec;
      assign pin_dlv_mode[n*3 +: 3] = cfg[n].dmode;
      assign pin_dest_mode[n]       = cfg[n].dstm;
      assign pin_trig_level[n]      = cfg[n].trig;
      assign pin_mask[n]            = cfg[n].mask;
      assign pin_dest[n*8 +: 8]     = cfg[n].dest;
   end

   irqr_rd_mux #(.NPIN(NPIN), .IDX_W(IDX_W)) u_mux (
      .idx      (idx_q),
      .tbl_hit  (tbl_hit),
      .tbl_hi   (tbl_hi),
      .tbl_pin  (tbl_pin),
      .id_word  (id_word),
      .ver_word (ver_word),
      .arb_word (arb_word),
      .lo_words (lo_words),
      .hi_words (hi_words),
      .rdata    (rd_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rd_next;
   end

   assign idx_rdata  = idx_q;
   assign data_rdata = rdata_q;

endmodule

// File: rtl/irqr_chk.sv
module irqr_chk #(
   parameter int         NPIN    = 24,
   parameter int         IDX_W   = 8,
   parameter logic [7:0] VERSION = 8'h11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              data_wr,
   input logic [IDX_W-1:0]  idx_rdata,
   input logic [31:0]       data_rdata,
   input logic [NPIN*8-1:0] pin_vector,
   input logic [NPIN-1:0]   pin_mask,
   input logic [NPIN*8-1:0] pin_dest
);

   localparam logic [31:0] VER_WORD = {8'h00, 8'(NPIN - 1), 8'h00, VERSION};

   logic in_tbl_hi;
   assign in_tbl_hi = (int'(idx_rdata) >= 16) && (int'(idx_rdata) < 16 + 2 * NPIN) && idx_rdata[0];

   AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(idx_rdata) == IDX_W'(1)) |-> (data_rdata == VER_WORD)); // R3

   AST_ID_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(idx_rdata) == IDX_W'(0)) |-> (data_rdata[23:0] == 24'h0 && data_rdata[31:28] == 4'h0)); // R2

   AST_ARB_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(idx_rdata) == IDX_W'(2)) |-> (data_rdata[23:0] == 24'h0 && data_rdata[31:28] == 4'h0)); // R4

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'($past(idx_rdata)) > 2) &&
       ((int'($past(idx_rdata)) < 16) || (int'($past(idx_rdata)) >= 16 + 2 * NPIN)))
      |-> (data_rdata == 32'h0)); // R8

   AST_HI_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && in_tbl_hi) |=> ($stable(pin_vector) && $stable(pin_mask))); // R6

   AST_IDLE_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!data_wr) |=> ($stable(pin_vector) && $stable(pin_mask) && $stable(pin_dest))); // R10

endmodule

bind irqr_regs irqr_chk #(.NPIN(NPIN), .IDX_W(IDX_W), .VERSION(VERSION)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .data_wr    (data_wr),
   .idx_rdata  (idx_rdata),
   .data_rdata (data_rdata),
   .pin_vector (pin_vector),
   .pin_mask   (pin_mask),
   .pin_dest   (pin_dest)
);

// File: tb/sim_irqr_regs.sv
module sim_irqr_regs;

   localparam int CLK_PERIOD = 10;
   localparam int NPIN       = 24;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              idx_wr = 1'b0;
   logic [7:0]        idx_wdata = '0;
   logic              data_wr = 1'b0;
   logic [31:0]       data_wdata = '0;
   logic [NPIN-1:0]   st_remote_irr = '0;
   logic [NPIN-1:0]   st_busy = '0;
   logic [7:0]        idx_rdata;
   logic [31:0]       data_rdata;
   logic [NPIN*8-1:0] pin_vector;
   logic [NPIN*3-1:0] pin_dlv_mode;
   logic [NPIN-1:0]   pin_dest_mode;
   logic [NPIN-1:0]   pin_trig_level;
   logic [NPIN-1:0]   pin_mask;
   logic [NPIN*8-1:0] pin_dest;

   irqr_regs #(.NPIN(NPIN)) u0 (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
      .data_wr(data_wr), .data_wdata(data_wdata),
      .st_remote_irr(st_remote_irr), .st_busy(st_busy),
      .idx_rdata(idx_rdata), .data_rdata(data_rdata),
      .pin_vector(pin_vector), .pin_dlv_mode(pin_dlv_mode),
      .pin_dest_mode(pin_dest_mode), .pin_trig_level(pin_trig_level),
      .pin_mask(pin_mask), .pin_dest(pin_dest)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   typedef struct {
      int          due;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sbq[$];
   int    cyc = 0;
   int    n_cmp = 0;
   int    n_bad = 0;
   bit    done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops due items and compares against registered read data
   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
         item_t it;
         it = sbq.pop_front();
         if (it.due < cyc) check({it.tag, " (missed)"}, 32'hDEAD_DEAD, it.exp);
         else              check(it.tag, data_rdata, it.exp);
      end
   end

   task automatic set_idx(input logic [7:0] v);
      idx_wr = 1'b1; idx_wdata = v;
      @(negedge clk);
      idx_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] v, input logic [31:0] exp, input string tag);
      item_t it;
      set_idx(v);
      it.due = cyc + 1; it.exp = exp; it.tag = tag;
      sbq.push_back(it);
      @(negedge clk);
   endtask

   task automatic wr(input logic [31:0] d);
      data_wr = 1'b1; data_wdata = d;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 index", {24'h0, idx_rdata}, 32'h0);
      check("R1 mask export", {8'h0, pin_mask}, {8'h0, {NPIN{1'b1}}});
      check("R1 vector export", pin_vector[31:0], 32'h0);
      rd(8'h00, 32'h0000_0000, "R1 id");
      rd(8'h10, 32'h0001_0000, "R1 pin0 low");
      rd(8'h3E, 32'h0001_0000, "R1 pin23 low");

      // R3 version
      rd(8'h01, 32'h0017_0011, "R3 version");
      wr(32'hFFE8_FFEE);
      rd(8'h01, 32'h0017_0011, "R3 version after write");

      // R2 id
      set_idx(8'h00);
      wr(32'hFFFF_FFFF);
      rd(8'h00, 32'h0F00_0000, "R2 id all ones");
      wr(32'h05A5_A5A5);
      rd(8'h00, 32'h0500_0000, "R2 id partial");

      // R4 arbitration mirror
      rd(8'h02, 32'h0500_0000, "R4 arb mirrors");
      wr(32'h0000_0000);
      rd(8'h02, 32'h0500_0000, "R4 arb ignores write");

      // R5 low word of pin 14, R10 export timing
      set_idx(8'h2C);
      wr(32'h0000_8A76);
      check("R10 R5 exports pin14",
            {pin_vector[14*8 +: 8], 5'b0, pin_dlv_mode[14*3 +: 3],
             5'b0, pin_dest_mode[14], pin_trig_level[14], pin_mask[14], 8'h0},
            {8'h76, 5'b0, 3'd2, 5'b0, 1'b1, 1'b1, 1'b0, 8'h0});
      rd(8'h2C, 32'h0000_8A76, "R5 pin14 low");

      // R6 high word isolation
      set_idx(8'h2D);
      wr(32'hFFFF_FFFF);
      check("R6 dest export", {24'h0, pin_dest[14*8 +: 8]}, 32'h0000_00FF);
      rd(8'h2D, 32'hFF00_0000, "R6 pin14 high");
      rd(8'h2C, 32'h0000_8A76, "R6 low kept");
      wr(32'h0000_8A77);
      rd(8'h2D, 32'hFF00_0000, "R6 dest kept");

      // R7 status bits
      set_idx(8'h2C);
      wr(32'h0000_DA77);
      rd(8'h2C, 32'h0000_8A77, "R7 status write ignored");
      st_remote_irr[14] = 1'b1;
      st_busy[14] = 1'b1;
      rd(8'h2C, 32'h0000_DA77, "R7 status reflected");
      st_remote_irr[14] = 1'b0;
      st_busy[14] = 1'b0;

      // R8 unmapped and index readback
      rd(8'h05, 32'h0, "R8 gap index");
      rd(8'h40, 32'h0, "R8 past table");
      rd(8'hFF, 32'h0, "R8 top index");
      check("R8 index readback", {24'h0, idx_rdata}, 32'h0000_00FF);

      // R9 registered read latency
      rd(8'h2C, 32'h0000_8A77, "R9 setup");
      set_idx(8'h01);
      check("R9 old data held one cycle", data_rdata, 32'h0000_8A77);
      @(negedge clk);
      check("R9 new data", data_rdata, 32'h0017_0011);

      // boundary pins
      set_idx(8'h3E);
      wr(32'h0000_0031);
      check("R5 pin23 exports", {23'h0, pin_mask[23], pin_vector[23*8 +: 8]}, 32'h0000_0031);
      check("R5 pin0 untouched", {31'h0, pin_mask[0]}, 32'h1);
      rd(8'h3E, 32'h0000_0031, "R5 pin23 low");

      repeat (3) @(negedge clk);
      if (sbq.size() != 0) check("scoreboard drained", sbq.size(), 0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule